// File: doc/BRIEF.md
# Clear-on-Read Measurement Status Register

This block holds the measurement status word of a multi-channel correlator. Each channel has a missed-data flag. The flag rises when a channel latches a new code-phase value before software has read the previous one. Two further flags are shared by all channels: a TIC flag, which marks the arrival of a new measurement epoch, and a measurement-interrupt flag. The interrupt flag is raised by the TIC pulse and also by an early-warning pulse that is supplied from outside the block.

Software reads the word through a single read strobe. A read returns the flags as they stood before the read, and it clears all of them. Each channel also has an internal "unread" marker. A code-phase latch strobe sets the marker and a code-phase read strobe clears it, and the missed-data detection is based on this marker. There are two reset sources. The hardware reset clears everything. The software reset clears only the missed-data flags and their markers, and leaves the TIC flag and the interrupt flag unchanged.

Top module: `meas_status_reg`

## Requirements
- R1: The word is {unused zeros, TIC, MEAS_INT, missed[NUM_CH-1:0]}. With 12 channels, bits 15..14 always read 0, bit 13 is TIC, bit 12 is MEAS_INT, and bit i (0..11) is the missed flag of channel i.
- R2: When an enabled channel receives a latch strobe while its unread marker is set, and no code-phase read strobe arrives in the same cycle, its missed flag is set on the next edge. A latch strobe always sets the marker. A code-phase read strobe without a latch strobe clears the marker.
- R3: While a channel's enable is low, its missed flag and its marker are cleared on each edge. After the channel is enabled again, its first latch strobe does not raise a missed flag.
- R4: The software reset clears every missed flag and every marker on the next edge. This takes precedence over a latch event in the same cycle.
- R5: A TIC pulse sets the TIC flag. A read without a TIC pulse clears it.
- R6: Either the TIC pulse or the pre-TIC pulse sets MEAS_INT. The pre-TIC pulse is used exactly as it arrives. A read without either pulse clears MEAS_INT.
- R7: The software reset does not change the TIC flag or the MEAS_INT flag.
- R8: The word presented during a read cycle holds the flags as they were before the clear. An event that arrives in the same cycle as a read leaves its flag set after that read.
- R9: The asynchronous active-low hardware reset makes the whole word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset, clears all flags |
| sw_rst | input | 1 | Synchronous software reset, clears missed flags and markers only |
| tic_pulse | input | 1 | Measurement epoch pulse |
| pretic_pulse | input | 1 | Early-warning pulse that raises MEAS_INT |
| latch_stb | input | NUM_CH | Per-channel code-phase latch strobe |
| cp_read_stb | input | NUM_CH | Per-channel code-phase read strobe |
| ch_en | input | NUM_CH | Per-channel enable |
| rd_en | input | 1 | Read strobe for this status word (clear-on-read) |
| rd_data | output | NUM_CH+4 | Current status word |

## Verification
The hardest situations to reach are the ones where several events meet on the same edge. Examples are a latch strobe on a channel whose marker is set, arriving together with a status read, a code-phase read, a software reset or a disable. Each of these has a defined winner. Directed sequences first prime a marker with one latch strobe and then apply each of these collisions in a single cycle. Seeded random stimulus then uses sparse latch and read strobes and occasional disables, so that markers stay set long enough for many such collisions to happen on their own.

// File: rtl/meas_status_pkg.sv
package meas_status_pkg;

  // Sticky flag: a set event wins over a clear in the same cycle.
  function automatic logic sticky_next(input logic set_i, input logic clr_i, input logic q_i);
    return set_i | (q_i & ~clr_i);
  endfunction

  // Unread marker: a new latch wins over a read in the same cycle.
  function automatic logic marker_next(input logic latch_i, input logic cpread_i, input logic q_i);
    return latch_i | (q_i & ~cpread_i);
  endfunction

  // Missed event: an unread value is overwritten and is not read in this cycle.
  function automatic logic missed_event(input logic latch_i, input logic cpread_i, input logic mark_i);
    return latch_i & mark_i & ~cpread_i;
  endfunction

endpackage

// File: rtl/ms_event_flag.sv
module ms_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  import meas_status_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= sticky_next(set_i, clr_i, flag_o);
  end
endmodule

// File: rtl/ms_chan_flag.sv
module ms_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sw_rst_i,
  input  logic latch_i,
  input  logic cpread_i,
  input  logic rd_i,
  output logic missed_o,
  output logic miss_evt_o
);
  import meas_status_pkg::*;

  logic mark_q;
  logic wipe;

  assign wipe       = ~en_i | sw_rst_i;
  assign miss_evt_o = ~wipe & missed_event(latch_i, cpread_i, mark_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q   <= 1'b0;
      missed_o <= 1'b0;
    end else if (wipe) begin
      mark_q   <= 1'b0;
      missed_o <= 1'b0;
    end else begin
      mark_q   <= marker_next(latch_i, cpread_i, mark_q);
      missed_o <= sticky_next(miss_evt_o, rd_i, missed_o);
    end
  end
endmodule

// File: rtl/meas_status_reg.sv
module meas_status_reg #(
  parameter int unsigned NUM_CH = 12,
  localparam int unsigned REG_W = NUM_CH + 4
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              sw_rst,
  input  logic              tic_pulse,
  input  logic              pretic_pulse,
  input  logic [NUM_CH-1:0] latch_stb,
  input  logic [NUM_CH-1:0] cp_read_stb,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned PAD_W = REG_W - NUM_CH - 2;

  logic [NUM_CH-1:0] missed;
  logic [NUM_CH-1:0] miss_evt;
  logic              tic_flag;
  logic              mint_flag;
  logic              mint_set;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    ms_chan_flag u_chan (
      .clk        (clk),
      .rst_n      (hw_rst_n),
      .en_i       (ch_en[c]),
      .sw_rst_i   (sw_rst),
      .latch_i    (latch_stb[c]),
      .cpread_i   (cp_read_stb[c]),
      .rd_i       (rd_en),
      .missed_o   (missed[c]),
      .miss_evt_o (miss_evt[c])
    );
  end

  assign mint_set = tic_pulse | pretic_pulse;

  ms_event_flag u_tic (
    .clk    (clk),
    .rst_n  (hw_rst_n),
    .set_i  (tic_pulse),
    .clr_i  (rd_en),
    .flag_o (tic_flag)
  );

  ms_event_flag u_mint (
    .clk    (clk),
    .rst_n  (hw_rst_n),
    .set_i  (mint_set),
    .clr_i  (rd_en),
    .flag_o (mint_flag)
  );

  assign rd_data = {{PAD_W{1'b0}}, tic_flag, mint_flag, missed};
endmodule

// File: rtl/meas_status_chk.sv
module meas_status_chk #(
  parameter int unsigned NUM_CH = 12,
  localparam int unsigned REG_W = NUM_CH + 4
) (
  input logic              clk,
  input logic              hw_rst_n,
  input logic              sw_rst,
  input logic              tic_pulse,
  input logic              pretic_pulse,
  input logic [NUM_CH-1:0] ch_en,
  input logic              rd_en,
  input logic [REG_W-1:0]  rd_data,
  input logic [NUM_CH-1:0] miss_evt
);
  localparam int unsigned TIC_B  = NUM_CH + 1;
  localparam int unsigned MINT_B = NUM_CH;

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!hw_rst_n)
    rd_data[REG_W-1:NUM_CH+2] == '0); // R1

  AST_TIC_SET: assert property (@(posedge clk) disable iff (!hw_rst_n)
    tic_pulse |=> rd_data[TIC_B]); // R5

  AST_TIC_CLR: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_en && !tic_pulse) |=> !rd_data[TIC_B]); // R5

  AST_MINT_PRE: assert property (@(posedge clk) disable iff (!hw_rst_n)
    pretic_pulse |=> rd_data[MINT_B]); // R6

  AST_MINT_CLR: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_en && !tic_pulse && !pretic_pulse) |=> !rd_data[MINT_B]); // R6

  AST_SWRST_MISSED: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_rst |=> rd_data[NUM_CH-1:0] == '0); // R4

  AST_SWRST_KEEP: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && !rd_en && !tic_pulse && !pretic_pulse) |=> $stable(rd_data[TIC_B:MINT_B])); // R7

  AST_READ_EVT: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_en && tic_pulse) |=> rd_data[TIC_B]); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_MISS_SET: assert property (@(posedge clk) disable iff (!hw_rst_n)
      miss_evt[c] |=> rd_data[c]); // R2
    AST_DIS_CLR: assert property (@(posedge clk) disable iff (!hw_rst_n)
      !ch_en[c] |=> !rd_data[c]); // R3
  end

  always @(posedge clk) begin
    if (!hw_rst_n) AST_HW_RST_ZERO: assert (rd_data == '0); // R9
  end
endmodule

bind meas_status_reg meas_status_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .hw_rst_n     (hw_rst_n),
  .sw_rst       (sw_rst),
  .tic_pulse    (tic_pulse),
  .pretic_pulse (pretic_pulse),
  .ch_en        (ch_en),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .miss_evt     (miss_evt)
);

// File: tb/meas_status_reg_tb.sv
module meas_status_reg_tb_top;
  localparam int unsigned NUM_CH = 12;
  localparam int unsigned REG_W  = NUM_CH + 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 20000;

  logic clk = 1'b0;
  logic hw_rst_n = 1'b0;
  logic sw_rst = 1'b0, tic_pulse = 1'b0, pretic_pulse = 1'b0, rd_en = 1'b0;
  logic [NUM_CH-1:0] latch_stb = '0, cp_read_stb = '0, ch_en = '0;
  logic [REG_W-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [NUM_CH-1:0] m_miss = '0, m_mark = '0;
  logic m_tic = 1'b0, m_mint = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  meas_status_reg #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .tic_pulse(tic_pulse),
    .pretic_pulse(pretic_pulse), .latch_stb(latch_stb), .cp_read_stb(cp_read_stb),
    .ch_en(ch_en), .rd_en(rd_en), .rd_data(rd_data));

  function automatic logic [REG_W-1:0] expect_word();
    logic [REG_W-1:0] w = '0;
    w[NUM_CH-1:0] = m_miss;
    w[NUM_CH]     = m_mint;
    w[NUM_CH+1]   = m_tic;
    return w;
  endfunction

  function automatic string field_req(input logic [REG_W-1:0] got, input logic [REG_W-1:0] exp);
    if (got[REG_W-1:NUM_CH+2] != exp[REG_W-1:NUM_CH+2]) return "R1";
    if (got[NUM_CH+1] != exp[NUM_CH+1]) return "R5";
    if (got[NUM_CH] != exp[NUM_CH]) return "R6";
    return "R2";
  endfunction

  task automatic verify(input string tag);
    logic [REG_W-1:0] exp = expect_word();
    n_chk++;
    if (rd_data !== exp) begin
      n_err++;
      $display("FAIL %s (field %s) cycle %0d: got %h expected %h",
               tag, field_req(rd_data, exp), cyc, rd_data, exp);
    end
  endtask

  // Reference update written per channel, independent of the design structure.
  task automatic model_step();
    for (int c = 0; c < NUM_CH; c++) begin
      if (!ch_en[c] || sw_rst) begin
        m_mark[c] = 1'b0;
        m_miss[c] = 1'b0;
      end else begin
        logic hit;
        hit = latch_stb[c] && m_mark[c] && !cp_read_stb[c];
        if (rd_en) m_miss[c] = 1'b0;
        if (hit) m_miss[c] = 1'b1;
        if (latch_stb[c]) m_mark[c] = 1'b1;
        else if (cp_read_stb[c]) m_mark[c] = 1'b0;
      end
    end
    if (rd_en) begin m_tic = 1'b0; m_mint = 1'b0; end
    if (tic_pulse) begin m_tic = 1'b1; m_mint = 1'b1; end
    if (pretic_pulse) m_mint = 1'b1;
  endtask

  // Checks the present word, then drives the inputs for the coming edge.
  task automatic step(input string tag, input logic [NUM_CH-1:0] en,
                      input logic [NUM_CH-1:0] lat, input logic [NUM_CH-1:0] cpr,
                      input logic rd, input logic tic, input logic pre, input logic sw);
    @(negedge clk);
    cyc++;
    verify(tag);
    ch_en = en; latch_stb = lat; cp_read_stb = cpr;
    rd_en = rd; tic_pulse = tic; pretic_pulse = pre; sw_rst = sw;
    model_step();
  endtask

  task automatic idle(input string tag);
    step(tag, '1, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic hw_reset(input string tag);
    @(negedge clk);
    hw_rst_n = 1'b0;
    sw_rst = 1'b0; tic_pulse = 1'b0; pretic_pulse = 1'b0; rd_en = 1'b0;
    latch_stb = '0; cp_read_stb = '0;
    m_miss = '0; m_mark = '0; m_tic = 1'b0; m_mint = 1'b0;
    @(negedge clk);
    @(negedge clk);
    verify(tag);
    hw_rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [NUM_CH-1:0] one3, one5;
    one3 = '0; one3[3] = 1'b1;
    one5 = '0; one5[5] = 1'b1;
    void'($urandom(32'd20211));

    // R9 / R1: reset state
    repeat (2) @(negedge clk);
    verify("R9");
    hw_rst_n = 1'b1;
    idle("R1");

    // R2: double latch on ch3 -> missed
    step("R2", '1, one3, '0, 0, 0, 0, 0);
    step("R2", '1, one3, '0, 0, 0, 0, 0);
    idle("R2");
    // R2: latch with concurrent code-phase read on ch5 -> no miss
    step("R2", '1, one5, '0, 0, 0, 0, 0);
    step("R2", '1, one5, one5, 0, 0, 0, 0);
    idle("R2");
    // R8: read together with a new miss event on ch5 and a TIC
    step("R8", '1, one5, '0, 1, 1, 0, 0);
    idle("R8");
    idle("R8");
    // R5/R6: read clears
    step("R5", '1, '0, '0, 1, 0, 0, 0);
    idle("R5");
    step("R6", '1, '0, '0, 0, 0, 1, 0);
    idle("R6");
    step("R6", '1, '0, '0, 1, 0, 0, 0);
    idle("R6");

    // R3: disable clears flag and marker
    step("R3", '1, one3, '0, 0, 0, 0, 0);
    step("R3", '1, one3, '0, 0, 0, 0, 0);
    step("R3", ~one3, '0, '0, 0, 0, 0, 0);
    idle("R3");
    step("R3", '1, one3, '0, 0, 0, 0, 0);
    idle("R3");

    // R4/R7: software reset clears missed only, beats a latch event
    step("R4", '1, one5, '0, 0, 1, 0, 0);
    step("R4", '1, one5, '0, 0, 0, 0, 0);
    idle("R4");
    step("R7", '1, one5 | one3, '0, 0, 0, 1, 1);
    idle("R7");
    idle("R4");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [NUM_CH-1:0] en, lat, cpr;
      en  = ($urandom % 16 == 0) ? NUM_CH'($urandom) : '1;
      lat = NUM_CH'($urandom) & NUM_CH'($urandom) & NUM_CH'($urandom);
      cpr = NUM_CH'($urandom) & NUM_CH'($urandom);
      step("R2", en, lat, cpr, ($urandom % 6) == 0, ($urandom % 20) == 0,
           ($urandom % 20) == 0, ($urandom % 40) == 0);
    end

    // R9: hardware reset mid-run with flags set
    step("R9", '1, '1, '0, 0, 1, 0, 0);
    step("R9", '1, '1, '0, 0, 0, 0, 0);
    idle("R9");
    hw_reset("R9");
    idle("R9");
    idle("R9");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule